// File: doc/BRIEF.md
# SPI Command Engine Register Front End

This block is the register-mapped control side of a command-driven SPI master. A host talks to it through a simple 32-bit register port with separate read and write strobes. Writes to two push registers feed a 16-bit command FIFO and an 8-bit transmit-data FIFO. Reads from a pop register drain an 8-bit receive-data FIFO. A second receive register returns the head entry without removing it. The command executor and the serial shifter sit outside this block. They take entries from the command and transmit FIFOs, push received bytes, and report sync commands through the core-side ports.

Further registers hold a version word, a soft-reset control bit for the executor, and the last sync ID seen. There are also read-only words giving the free room of the command and transmit FIFOs and the fill level of the receive FIFO. Four interrupt causes are tracked:
- the command FIFO is almost empty;
- the transmit FIFO is almost empty;
- the receive FIFO is almost full;
- a sync command has executed.

Each cause has a pending bit that is cleared by writing 1 to it and an enable bit. The interrupt line is a level output.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A read of offset 0x00 returns major 1 in bits 23:16, the minor parameter in bits 15:8 and the patch parameter in bits 7:0. Every read result appears on `rd_data_o` one clock after the read strobe and holds until the next read. Unmapped offsets read as zero.
- R2: The soft-reset register at 0x40 resets to 1. Bit 0 of a write sets it, and it drives `core_rst_o`; it reads back in bit 0.
- R3: The enable register at 0x80 holds bits 3:0 of the last write, resets to zero and reads back.
- R4: The source register at 0x88 reads the unmasked conditions. Bit 0 is set when the command FIFO level is at most CMD_AE. Bit 1 is set when the transmit FIFO level is at most TX_AE. Bit 2 is set when the receive FIFO level is at least RX_DEPTH-RX_AF. Bit 3 is the latched sync pending bit.
- R5: The pending register at 0x84 sets a bit in every cycle its condition holds (bits 0..2) or a sync event arrives (bit 3). Writing 1 to a bit clears it. When a set and a clear meet in the same cycle, the set wins.
- R6: `irq_o` is high exactly when some pending bit is also enabled.
- R7: A sync event on `sync_evt_i` captures `sync_id_i` into the register at 0xC0 and sets pending bit 3.
- R8: A write to 0xE0 pushes bits 15:0 into the command FIFO unless the FIFO is full, in which case the write is ignored. Offset 0xD0 reads the free room, which reflects a push or pop from the clock edge on which it happens.
- R9: A write to 0xE4 pushes bits 7:0 into the transmit FIFO unless the FIFO is full. Offset 0xD4 reads the free room.
- R10: A read of 0xE8 returns the receive FIFO head and pops it. On an empty FIFO the read returns zero and changes nothing. Offset 0xD8 reads the fill level.
- R11: A read of 0xEC returns the receive FIFO head, or zero when the FIFO is empty, and never changes the level.
- R12: On the core side, `cmd_valid_o` and `tx_valid_o` flag a non-empty FIFO and show its head, and a pop of an empty FIFO is ignored. `rx_ready_o` is low when the receive FIFO is full, and a push while it is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Level interrupt |
| core_rst_o | output | 1 | Soft reset to the command executor |
| cmd_valid_o | output | 1 | Command FIFO not empty |
| cmd_data_o | output | 16 | Command FIFO head |
| cmd_pop_i | input | 1 | Executor takes the command head |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_data_o | output | 8 | Transmit FIFO head |
| tx_pop_i | input | 1 | Shifter takes the transmit head |
| rx_ready_o | output | 1 | Receive FIFO has room |
| rx_push_i | input | 1 | Shifter delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| sync_evt_i | input | 1 | A sync command executed |
| sync_id_i | input | 8 | ID carried by that sync command |

## Verification
Register reads take one edge: the value sampled at the edge where `rd_en_i` is high shows on `rd_data_o` after that edge. Pushes, pops, enable and reset writes, and sync capture also take effect at the stimulus edge, so `irq_o`, the valid and ready flags and the FIFO heads change right after it. A watermark pending bit lags by one more edge, because it samples the registered FIFO level. The bench advances a behavioural model once per rising edge using the inputs it applied, and compares every output at the following falling edge. Each comparison therefore lands in the first cycle where the new value is due.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned IRQ_N  = 4;

  localparam logic [ADDR_W-1:0] A_VER      = 8'h00;
  localparam logic [ADDR_W-1:0] A_SRST     = 8'h40;
  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 8'h80;
  localparam logic [ADDR_W-1:0] A_IRQ_PEND = 8'h84;
  localparam logic [ADDR_W-1:0] A_IRQ_SRC  = 8'h88;
  localparam logic [ADDR_W-1:0] A_SYNC_ID  = 8'hC0;
  localparam logic [ADDR_W-1:0] A_CMD_ROOM = 8'hD0;
  localparam logic [ADDR_W-1:0] A_TX_ROOM  = 8'hD4;
  localparam logic [ADDR_W-1:0] A_RX_LVL   = 8'hD8;
  localparam logic [ADDR_W-1:0] A_CMD_PUSH = 8'hE0;
  localparam logic [ADDR_W-1:0] A_TX_PUSH  = 8'hE4;
  localparam logic [ADDR_W-1:0] A_RX_POP   = 8'hE8;
  localparam logic [ADDR_W-1:0] A_RX_PEEK  = 8'hEC;

  localparam int unsigned IRQ_CMD_LOW = 0;
  localparam int unsigned IRQ_TX_LOW  = 1;
  localparam int unsigned IRQ_RX_HIGH = 2;
  localparam int unsigned IRQ_SYNC    = 3;

  localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/fe_fifo.sv
module fe_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign count_o = cnt;
  assign data_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (count_o == $past(count_o)));
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/fe_irq.sv
module fe_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_d_i;
      // set has priority over write-one-to-clear
      pend_q <= (pend_q & ~clr_i) | set_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_q);

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|en_o));
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int unsigned CMD_W     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SYNC_W    = 8,
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned TX_DEPTH  = 16,
  parameter int unsigned RX_DEPTH  = 16,
  parameter int unsigned CMD_AE    = CMD_DEPTH / 4,
  parameter int unsigned TX_AE     = TX_DEPTH / 4,
  parameter int unsigned RX_AF     = RX_DEPTH / 4,
  parameter logic [7:0]  VER_MINOR = 8'h00,
  parameter logic [7:0]  VER_PATCH = 8'h61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [7:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o,
  output logic              core_rst_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_data_o,
  input  logic              cmd_pop_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_pop_i,
  output logic              rx_ready_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              sync_evt_i,
  input  logic [SYNC_W-1:0] sync_id_i
);
  localparam int unsigned CCW = $clog2(CMD_DEPTH + 1);
  localparam int unsigned TCW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RCW = $clog2(RX_DEPTH + 1);
  localparam int unsigned RX_HI = RX_DEPTH - RX_AF;

  logic [CCW-1:0]    cmd_cnt;
  logic [TCW-1:0]    tx_cnt;
  logic [RCW-1:0]    rx_cnt;
  logic              cmd_empty, tx_empty, rx_empty, rx_full;
  logic              unused_cmd_full, unused_tx_full;
  logic [DATA_W-1:0] rx_head;
  logic              cmd_push, tx_push, rx_pop;
  logic [IRQ_N-1:0]  cond, irq_set, irq_clr, irq_en, irq_pend;
  logic              srst_q;
  logic [SYNC_W-1:0] sync_q;
  logic [31:0]       rd_val;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data_i[31:CMD_W];

  assign cmd_push = wr_en_i && (wr_addr_i == A_CMD_PUSH);
  assign tx_push  = wr_en_i && (wr_addr_i == A_TX_PUSH);
  assign rx_pop   = rd_en_i && (rd_addr_i == A_RX_POP);

  fe_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk_i, .rst_ni,
    .push_i (cmd_push), .data_i (wr_data_i[CMD_W-1:0]),
    .pop_i  (cmd_pop_i), .data_o (cmd_data_o),
    .count_o(cmd_cnt), .full_o (unused_cmd_full), .empty_o(cmd_empty)
  );

  fe_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push), .data_i (wr_data_i[DATA_W-1:0]),
    .pop_i  (tx_pop_i), .data_o (tx_data_o),
    .count_o(tx_cnt), .full_o (unused_tx_full), .empty_o(tx_empty)
  );

  fe_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push_i), .data_i (rx_data_i),
    .pop_i  (rx_pop), .data_o (rx_head),
    .count_o(rx_cnt), .full_o (rx_full), .empty_o(rx_empty)
  );

  assign cmd_valid_o = !cmd_empty;
  assign tx_valid_o  = !tx_empty;
  assign rx_ready_o  = !rx_full;

  // raw conditions, before pending and enable
  always_comb begin
    cond              = '0;
    cond[IRQ_CMD_LOW] = (cmd_cnt <= CCW'(CMD_AE));
    cond[IRQ_TX_LOW]  = (tx_cnt  <= TCW'(TX_AE));
    cond[IRQ_RX_HIGH] = (rx_cnt  >= RCW'(RX_HI));
  end

  always_comb begin
    irq_set           = cond;
    irq_set[IRQ_SYNC] = sync_evt_i;
    irq_clr = (wr_en_i && wr_addr_i == A_IRQ_PEND) ? wr_data_i[IRQ_N-1:0] : '0;
  end

  fe_irq #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni,
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .en_we_i(wr_en_i && wr_addr_i == A_IRQ_EN),
    .en_d_i (wr_data_i[IRQ_N-1:0]),
    .en_o   (irq_en),
    .pend_o (irq_pend),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b1;
      sync_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_SRST) srst_q <= wr_data_i[0];
      if (sync_evt_i) sync_q <= sync_id_i;
    end
  end
  assign core_rst_o = srst_q;

  always_comb begin
    rd_val = '0;
    unique case (rd_addr_i)
      A_VER:      rd_val = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
      A_SRST:     rd_val = 32'(srst_q);
      A_IRQ_EN:   rd_val = 32'(irq_en);
      A_IRQ_PEND: rd_val = 32'(irq_pend);
      A_IRQ_SRC:  rd_val = 32'({irq_pend[IRQ_SYNC], cond[IRQ_SYNC-1:0]});
      A_SYNC_ID:  rd_val = 32'(sync_q);
      A_CMD_ROOM: rd_val = 32'(CCW'(CMD_DEPTH) - cmd_cnt);
      A_TX_ROOM:  rd_val = 32'(TCW'(TX_DEPTH) - tx_cnt);
      A_RX_LVL:   rd_val = 32'(rx_cnt);
      A_RX_POP,
      A_RX_PEEK:  rd_val = 32'(rx_head);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_val;
  end

  p_ver_major_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_VER) |=> (rd_data_o[23:16] == 8'd1));
  p_rx_empty_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |=> (rd_data_o == '0));
  p_peek_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_RX_PEEK && !rx_push_i) |=> (rx_cnt == $past(rx_cnt)));
  p_sync_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt_i |=> irq_pend[IRQ_SYNC]);
endmodule

// File: tb/test_spi_cmd_frontend.sv
module test_spi_cmd_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int CD = 16, TD = 16, RD = 16;
  localparam int CAE = CD / 4, TAE = TD / 4, RAF = RD / 4;
  localparam logic [7:0] MINOR = 8'h00, PATCH = 8'h61;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en, rd_en, cmd_pop, tx_pop, rx_push, sync_evt;
  logic [7:0]  wr_addr, rd_addr, rx_data, sync_id;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq, core_rst, cmd_valid, tx_valid, rx_ready;
  logic [15:0] cmd_data;
  logic [7:0]  tx_data;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] cmd_q[$];
  logic [7:0]  tx_q[$], rx_q[$];
  logic [3:0]  m_pend = '0, m_en = '0;
  logic        m_srst = 1'b1;
  logic [7:0]  m_sync = '0;
  logic [31:0] m_rd = '0;
  string       rd_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_frontend i_spi_cmd_frontend (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .core_rst_o(core_rst),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_pop_i(cmd_pop),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_pop_i(tx_pop),
    .rx_ready_o(rx_ready), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .sync_evt_i(sync_evt), .sync_id_i(sync_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h40: return "R2";
      8'h80: return "R3";
      8'h88: return "R4";
      8'h84: return "R5";
      8'hC0: return "R7";
      8'hD0: return "R8";
      8'hD4: return "R9";
      8'hD8, 8'hE8: return "R10";
      8'hEC: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic idle();
    wr_en = 0; rd_en = 0; cmd_pop = 0; tx_pop = 0; rx_push = 0; sync_evt = 0;
    wr_addr = 0; rd_addr = 0; wr_data = 0; rx_data = 0; sync_id = 0;
  endtask

  task automatic model_step();
    logic [3:0] src, clr;
    bit c_full, c_empty, t_full, t_empty, r_full, r_empty;
    c_full = cmd_q.size() == CD; c_empty = cmd_q.size() == 0;
    t_full = tx_q.size() == TD;  t_empty = tx_q.size() == 0;
    r_full = rx_q.size() == RD;  r_empty = rx_q.size() == 0;
    src[0] = cmd_q.size() <= CAE;
    src[1] = tx_q.size() <= TAE;
    src[2] = rx_q.size() >= RD - RAF;
    src[3] = m_pend[3];
    if (rd_en) begin
      rd_tag = tag_of(rd_addr);
      case (rd_addr)
        8'h00: m_rd = {8'h00, 8'd1, MINOR, PATCH};
        8'h40: m_rd = 32'(m_srst);
        8'h80: m_rd = 32'(m_en);
        8'h84: m_rd = 32'(m_pend);
        8'h88: m_rd = 32'(src);
        8'hC0: m_rd = 32'(m_sync);
        8'hD0: m_rd = CD - cmd_q.size();
        8'hD4: m_rd = TD - tx_q.size();
        8'hD8: m_rd = rx_q.size();
        8'hE8, 8'hEC: m_rd = r_empty ? 32'd0 : 32'(rx_q[0]);
        default: m_rd = 0;
      endcase
      if (rd_addr == 8'hE8 && !r_empty) void'(rx_q.pop_front());
    end
    if (cmd_pop && !c_empty) void'(cmd_q.pop_front());
    if (wr_en && wr_addr == 8'hE0 && !c_full) cmd_q.push_back(wr_data[15:0]);
    if (tx_pop && !t_empty) void'(tx_q.pop_front());
    if (wr_en && wr_addr == 8'hE4 && !t_full) tx_q.push_back(wr_data[7:0]);
    if (rx_push && !r_full) rx_q.push_back(rx_data);
    clr = (wr_en && wr_addr == 8'h84) ? wr_data[3:0] : 4'h0;
    m_pend = (m_pend & ~clr) | {sync_evt, src[2:0]};
    if (wr_en && wr_addr == 8'h80) m_en = wr_data[3:0];
    if (wr_en && wr_addr == 8'h40) m_srst = wr_data[0];
    if (sync_evt) m_sync = sync_id;
  endtask

  task automatic cmp_all();
    chk(rd_tag, rd_data, m_rd);
    chk("R6 irq", 32'(irq), 32'(|(m_pend & m_en)));
    chk("R2 core_rst", 32'(core_rst), 32'(m_srst));
    chk("R12 cmd_valid", 32'(cmd_valid), 32'(cmd_q.size() != 0));
    chk("R12 cmd_data", 32'(cmd_data), cmd_q.size() != 0 ? 32'(cmd_q[0]) : 32'd0);
    chk("R12 tx_valid", 32'(tx_valid), 32'(tx_q.size() != 0));
    chk("R12 tx_data", 32'(tx_data), tx_q.size() != 0 ? 32'(tx_q[0]) : 32'd0);
    chk("R12 rx_ready", 32'(rx_ready), 32'(rx_q.size() < RD));
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    cmp_all();
    idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1; rd_addr = a; step();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cmp_all(); // reset state: R2 core_rst high, R6 irq low

    // R1 version and unmapped
    rd(8'h00); chk("R1 version", rd_data, {8'h00, 8'd1, MINOR, PATCH});
    rd(8'h10); chk("R1 unmapped", rd_data, 32'd0);
    step(); chk("R1 hold", rd_data, 32'd0);
    // R2 soft reset
    rd(8'h40); chk("R2 reset value", rd_data, 32'd1);
    wr(8'h40, 32'h0); chk("R2 released", 32'(core_rst), 32'd0);
    rd(8'h40);
    // R3 enable, R6 irq from watermark pending
    wr(8'h80, 32'hF); rd(8'h80); chk("R3 enable readback", rd_data, 32'hF);
    chk("R6 irq on", 32'(irq), 32'd1);
    // R4 raw source: both TX-side FIFOs empty
    rd(8'h88); chk("R4 source empty", rd_data, 32'h3);
    // R5 W1C with condition still present: set wins
    wr(8'h84, 32'hFF); rd(8'h84); chk("R5 set wins", rd_data, 32'h3);
    wr(8'h80, 32'h0); chk("R6 irq masked", 32'(irq), 32'd0);

    // R8 command FIFO fill, overflow ignored
    for (int i = 0; i < CD + 1; i++) wr(8'hE0, 32'hABC00000 | i);
    rd(8'hD0); chk("R8 room full", rd_data, 32'd0);
    rd(8'h88); chk("R4 cmd not low", rd_data[0], 1'b0);
    // pop with concurrent push
    cmd_pop = 1; wr(8'hE0, 32'h1234);
    for (int i = 0; i < CD + 2; i++) begin cmd_pop = 1; step(); end
    rd(8'hD0); chk("R8 room empty", rd_data, 32'(CD));

    // R9 transmit FIFO
    for (int i = 0; i < TD + 2; i++) wr(8'hE4, 32'h100 + i);
    rd(8'hD4); chk("R9 room full", rd_data, 32'd0);
    for (int i = 0; i < 5; i++) begin tx_pop = 1; step(); end
    rd(8'hD4); chk("R9 room after pops", rd_data, 32'd5);

    // R10/R11 receive FIFO
    rd(8'hE8); chk("R10 empty pop zero", rd_data, 32'd0);
    rd(8'hEC); chk("R11 empty peek zero", rd_data, 32'd0);
    for (int i = 0; i < RD + 1; i++) begin rx_push = 1; rx_data = 8'h40 + i; step(); end
    chk("R12 rx full", 32'(rx_ready), 32'd0);
    rd(8'hD8); chk("R10 level", rd_data, 32'(RD));
    rd(8'h88); chk("R4 rx high", rd_data[2], 1'b1);
    rd(8'hEC); rd(8'hEC); chk("R11 peek head", rd_data, 32'h40);
    rd(8'hD8); chk("R11 level kept", rd_data, 32'(RD));
    for (int i = 0; i < RD + 1; i++) rd(8'hE8);
    chk("R10 drained pop zero", rd_data, 32'd0);

    // R7 sync capture, R5/R6 on the sync bit
    wr(8'h80, 32'h8);
    sync_evt = 1; sync_id = 8'h5A; step();
    chk("R6 sync irq", 32'(irq), 32'd1);
    rd(8'hC0); chk("R7 sync id", rd_data, 32'h5A);
    wr(8'h84, 32'h8); chk("R5 sync cleared", 32'(irq), 32'd0);
    sync_evt = 1; sync_id = 8'hC3; wr_en = 1; wr_addr = 8'h84; wr_data = 32'h8; step();
    chk("R5 sync set wins", 32'(irq), 32'd1);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [7:0] addrs [14] = '{8'h00, 8'h40, 8'h80, 8'h84, 8'h88, 8'hC0,
                                 8'hD0, 8'hD4, 8'hD8, 8'hE0, 8'hE4, 8'hE8, 8'hEC, 8'h24};
      r = $urandom_range(0, 9);
      if (r < 5) begin
        wr_en = 1; wr_addr = addrs[$urandom_range(0, 13)]; wr_data = $urandom();
        if (wr_addr == 8'h40) wr_data[0] = ($urandom_range(0, 7) == 0);
      end
      if ($urandom_range(0, 2) == 0) begin rd_en = 1; rd_addr = addrs[$urandom_range(0, 13)]; end
      cmd_pop  = ($urandom_range(0, 2) == 0);
      tx_pop   = ($urandom_range(0, 2) == 0);
      rx_push  = ($urandom_range(0, 3) == 0);
      rx_data  = 8'($urandom());
      sync_evt = ($urandom_range(0, 40) == 0);
      sync_id  = 8'($urandom());
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule